// File: doc/BRIEF.md
# DRAM Refresh Scheduler

This block keeps an asynchronous DRAM's cells refreshed on behalf of a memory access controller. An interval timer marks a refresh as owed once every `INTERVAL` clock cycles. When it has an owed refresh, the scheduler raises a request and waits for the access controller to hand over the bus with `grant`. It then drives the strobes for one refresh cycle itself. The style is picked by `row_mode`. With `row_mode` low it issues CAS-before-RAS cycles, where the device's own row counter chooses the row. With `row_mode` high it issues RAS-only cycles, taking the row from a counter held in the block. Refreshes that are not granted at once are counted. An urgent flag tells the controller when that backlog has grown large.

The scheduler also handles the host's self-refresh requests. Entry and exit each carry obligations that depend on the refresh style in use:
- **CAS-before-RAS style:** one CAS-before-RAS cycle leads into self refresh, and exactly one more follows the exit precharge.
- **RAS-only style:** a full sweep over every row comes before entry and another follows exit.

RAS is held low for a minimum number of cycles while the device refreshes itself. A longer precharge follows the exit.

Top module: `rfsh_sched`

## Requirements
- R1: A refresh becomes owed every `INTERVAL` cycles. The first one is owed after edge number `INTERVAL` following reset release. With `grant` held high, exactly one refresh is issued per interval.
- R2: A CAS-before-RAS refresh drives `cas_n` low for `T_CS` cycles while `ras_n` is high. It then holds `ras_n` low for `T_RAS` cycles and `rf_kind` reads 1 (CAS-before-RAS) during the cycle. `we_n` stays high throughout, and `T_RP` precharge cycles with all strobes high follow.
- R3: A RAS-only refresh holds `cas_n` high while `ras_n` is low for `T_RAS` cycles. `row_addr` stays stable over that time, and `rf_kind` reads 2 (RAS-only).
- R4: The internal row counter starts at 0 after reset and advances by one, modulo `ROWS`, after every RAS-only cycle. This includes the cycles inside self-refresh sweeps.
- R5: Self-refresh entry starts only when `sr_req` and `grant` are both high. `sr_active` is then high for at least `SR_MIN_CYC` cycles and stays high for as long as `sr_req` remains high.
- R6: Self-refresh exit keeps `ras_n` high for `SR_RP` cycles. In CAS-before-RAS style, exactly one CAS-before-RAS cycle follows, and then the bus is released.
- R7: In RAS-only style, exactly `ROWS` RAS-only cycles come before the CAS-before-RAS cycle that enters self refresh, and exactly `ROWS` RAS-only cycles follow the exit precharge.
- R8: Refreshes that are owed but not granted are counted. `rf_urgent` rises when the count reaches `URGENT_TH`, and it falls again once granted refreshes drain the count.
- R9: After reset all strobes are high, and `rf_req`, `rf_urgent`, `busy`, `sr_active` and `rf_kind` are all 0.
- R10: No refresh or self-refresh sequence starts without `grant`. `rf_req` is high while the block is idle and either a refresh is owed or `sr_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_mode | input | 1 | 0: CAS-before-RAS refresh, 1: RAS-only refresh with internal row counter |
| sr_req | input | 1 | Host request to enter and remain in self refresh |
| grant | input | 1 | Bus handed to the scheduler by the access controller |
| rf_req | output | 1 | Scheduler wants the bus |
| rf_urgent | output | 1 | Postponed refresh count has reached the threshold |
| rf_kind | output | 2 | Cycle in progress: 0 none, 1 CAS-before-RAS, 2 RAS-only |
| row_addr | output | $clog2(ROWS) | Row for RAS-only cycles |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, held high |
| sr_active | output | 1 | Device is in self refresh |
| busy | output | 1 | Scheduler owns the bus |

## Verification
The bench targets the places where the scheduler can silently violate refresh timing:
- **CAS lead:** the number of cycles CAS leads RAS on each CAS-before-RAS cycle. A design that dropped the lead would produce a RAS-only cycle to a random row.
- **Row counter wrap:** the row sequence over several wraps. A design that got the wrap wrong would skip or repeat rows and lose data.
- **Self-refresh hold:** the minimum hold when the host releases `sr_req` early. A design that got this wrong would wake the device too soon.
- **Exit obligations per style:** a scheduler that issued none after exit, or issued them for the wrong style, would miss or waste a full sweep.
- **Backlog:** the urgent threshold at the exact edge where it is reached, and its clearing as the backlog drains.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  typedef enum logic [1:0] {
    RK_NONE = 2'd0,
    RK_CBR  = 2'd1,
    RK_ROR  = 2'd2
  } rf_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CBR_SET, ST_CBR_RAS, ST_ROR, ST_PRE, ST_SR_HOLD, ST_SR_PRE
  } rf_state_e;

  typedef enum logic [1:0] {
    CX_NORM, CX_ENTRY, CX_EXIT
  } rf_ctx_e;
endpackage

// File: rtl/rfsh_owe_ctr.sv
module rfsh_owe_ctr #(
  parameter int INTERVAL  = 1950,
  parameter int OWE_MAX   = 15,
  parameter int URGENT_TH = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic take,
  output logic pending,
  output logic urgent
);
  localparam int TW = $clog2(INTERVAL);
  localparam int OW = $clog2(OWE_MAX + 1);

  logic [TW-1:0] tmr_q;
  logic [OW-1:0] owed_q;
  logic          tick;

  assign tick = (tmr_q == TW'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (rst || hold) begin
      tmr_q  <= '0;
      owed_q <= '0;
    end else begin
      tmr_q <= tick ? '0 : tmr_q + 1'b1;
      if (tick && !take && owed_q != OW'(OWE_MAX))
        owed_q <= owed_q + 1'b1;
      else if (take && !tick)
        owed_q <= owed_q - 1'b1;
    end
  end

  assign pending = (owed_q != '0);
  assign urgent  = (owed_q >= OW'(URGENT_TH));
endmodule

// File: rtl/rfsh_row_ctr.sv
module rfsh_row_ctr #(
  parameter int ROWS = 4096
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    adv,
  output logic [$clog2(ROWS)-1:0] row
);
  localparam int RAW = $clog2(ROWS);

  always_ff @(posedge clk) begin
    if (rst)
      row <= '0;
    else if (adv)
      row <= (row == RAW'(ROWS - 1)) ? '0 : row + 1'b1;
  end
endmodule

// File: rtl/rfsh_seq.sv
module rfsh_seq
  import rfsh_pkg::*;
#(
  parameter int ROWS       = 4096,
  parameter int T_CS       = 2,
  parameter int T_RAS      = 8,
  parameter int T_RP       = 5,
  parameter int SR_MIN_CYC = 12500,
  parameter int SR_RP      = 14
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       row_mode,
  input  logic       sr_req,
  input  logic       grant,
  input  logic       pending,
  output logic       take,
  output logic       hold_owe,
  output logic       row_adv,
  output logic       ras_n,
  output logic       cas_n,
  output logic       we_n,
  output logic [1:0] kind,
  output logic       sr_active,
  output logic       busy
);
  localparam int CW = $clog2(SR_MIN_CYC + SR_RP + T_RAS + T_CS + T_RP + 2);
  localparam int BW = $clog2(ROWS + 1);
  localparam logic [CW-1:0] L_CS    = CW'(T_CS - 1);
  localparam logic [CW-1:0] L_RAS   = CW'(T_RAS - 1);
  localparam logic [CW-1:0] L_RP    = CW'(T_RP - 1);
  localparam logic [CW-1:0] L_SRMIN = CW'(SR_MIN_CYC - 1);
  localparam logic [CW-1:0] L_SRRP  = CW'(SR_RP - 1);

  rf_state_e     state_q, state_d;
  rf_ctx_e       ctx_q, ctx_d;
  logic          mode_q, mode_d;
  logic [BW-1:0] left_q, left_d;
  logic [CW-1:0] tcnt_q;

  always_comb begin
    state_d = state_q;
    ctx_d   = ctx_q;
    mode_d  = mode_q;
    left_d  = left_q;
    unique case (state_q)
      ST_IDLE: begin
        if (grant && sr_req) begin
          ctx_d   = CX_ENTRY;
          mode_d  = row_mode;
          left_d  = BW'(ROWS);
          state_d = row_mode ? ST_ROR : ST_CBR_SET;
        end else if (grant && pending) begin
          ctx_d   = CX_NORM;
          mode_d  = row_mode;
          state_d = row_mode ? ST_ROR : ST_CBR_SET;
        end
      end
      ST_CBR_SET: if (tcnt_q == L_CS) state_d = ST_CBR_RAS;
      ST_CBR_RAS: if (tcnt_q == L_RAS)
        state_d = (ctx_q == CX_ENTRY) ? ST_SR_HOLD : ST_PRE;
      ST_ROR: if (tcnt_q == L_RAS) state_d = ST_PRE;
      ST_PRE: begin
        if (tcnt_q == L_RP) begin
          if (mode_q && ctx_q != CX_NORM && left_q > BW'(1)) begin
            left_d  = left_q - 1'b1;
            state_d = ST_ROR;
          end else if (mode_q && ctx_q == CX_ENTRY) begin
            state_d = ST_CBR_SET;
          end else begin
            state_d = ST_IDLE;
          end
        end
      end
      ST_SR_HOLD: if (tcnt_q >= L_SRMIN && !sr_req) state_d = ST_SR_PRE;
      ST_SR_PRE: begin
        if (tcnt_q == L_SRRP) begin
          ctx_d   = CX_EXIT;
          left_d  = BW'(ROWS);
          state_d = mode_q ? ST_ROR : ST_CBR_SET;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      ctx_q     <= CX_NORM;
      mode_q    <= 1'b0;
      left_q    <= '0;
      tcnt_q    <= '0;
      ras_n     <= 1'b1;
      cas_n     <= 1'b1;
      we_n      <= 1'b1;
      kind      <= RK_NONE;
      sr_active <= 1'b0;
      busy      <= 1'b0;
    end else begin
      state_q   <= state_d;
      ctx_q     <= ctx_d;
      mode_q    <= mode_d;
      left_q    <= left_d;
      if (state_d != state_q)
        tcnt_q <= '0;
      else if (tcnt_q != '1)
        tcnt_q <= tcnt_q + 1'b1;
      ras_n     <= !(state_d inside {ST_CBR_RAS, ST_ROR, ST_SR_HOLD});
      cas_n     <= !(state_d inside {ST_CBR_SET, ST_CBR_RAS, ST_SR_HOLD});
      we_n      <= 1'b1;
      kind      <= (state_d inside {ST_CBR_SET, ST_CBR_RAS, ST_SR_HOLD}) ? RK_CBR :
                   (state_d == ST_ROR) ? RK_ROR : RK_NONE;
      sr_active <= (state_d == ST_SR_HOLD);
      busy      <= (state_d != ST_IDLE);
    end
  end

  assign take     = (state_q == ST_IDLE) && grant && !sr_req && pending;
  assign hold_owe = (state_q == ST_SR_HOLD);
  assign row_adv  = (state_q == ST_ROR) && (tcnt_q == L_RAS);
endmodule

// File: rtl/rfsh_sched.sv
module rfsh_sched #(
  parameter int INTERVAL   = 1950,
  parameter int ROWS       = 4096,
  parameter int OWE_MAX    = 15,
  parameter int URGENT_TH  = 8,
  parameter int T_CS       = 2,
  parameter int T_RAS      = 8,
  parameter int T_RP       = 5,
  parameter int SR_MIN_CYC = 12500,
  parameter int SR_RP      = 14
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    row_mode,
  input  logic                    sr_req,
  input  logic                    grant,
  output logic                    rf_req,
  output logic                    rf_urgent,
  output logic [1:0]              rf_kind,
  output logic [$clog2(ROWS)-1:0] row_addr,
  output logic                    ras_n,
  output logic                    cas_n,
  output logic                    we_n,
  output logic                    sr_active,
  output logic                    busy
);
  logic pending, take, hold_owe, row_adv;

  rfsh_owe_ctr #(.INTERVAL(INTERVAL), .OWE_MAX(OWE_MAX), .URGENT_TH(URGENT_TH)) owe_i (
    .clk(clk), .rst(rst), .hold(hold_owe), .take(take),
    .pending(pending), .urgent(rf_urgent)
  );

  rfsh_row_ctr #(.ROWS(ROWS)) row_i (
    .clk(clk), .rst(rst), .adv(row_adv), .row(row_addr)
  );

  rfsh_seq #(
    .ROWS(ROWS), .T_CS(T_CS), .T_RAS(T_RAS), .T_RP(T_RP),
    .SR_MIN_CYC(SR_MIN_CYC), .SR_RP(SR_RP)
  ) seq_i (
    .clk(clk), .rst(rst), .row_mode(row_mode), .sr_req(sr_req), .grant(grant),
    .pending(pending), .take(take), .hold_owe(hold_owe), .row_adv(row_adv),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .kind(rf_kind),
    .sr_active(sr_active), .busy(busy)
  );

  assign rf_req = !busy && (pending || sr_req);
endmodule

// File: rtl/rfsh_sched_chk.sv
module rfsh_sched_chk #(
  parameter int ROWS       = 4096,
  parameter int SR_MIN_CYC = 12500
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    grant,
  input logic                    rf_req,
  input logic                    rf_urgent,
  input logic [1:0]              rf_kind,
  input logic [$clog2(ROWS)-1:0] row_addr,
  input logic                    ras_n,
  input logic                    cas_n,
  input logic                    sr_active,
  input logic                    busy
);
  localparam int HW = $clog2(SR_MIN_CYC + 2) + 1;
  logic [HW-1:0] hold_cnt;

  always_ff @(posedge clk) begin
    if (rst || !sr_active)
      hold_cnt <= '0;
    else if (hold_cnt != '1)
      hold_cnt <= hold_cnt + 1'b1;
  end

  // R2
  cbr_cas_lead_chk: assert property (@(posedge clk) disable iff (rst)
    ($fell(ras_n) && rf_kind == 2'd1) |-> $past(!cas_n));

  // R3
  ror_cas_high_chk: assert property (@(posedge clk) disable iff (rst)
    (!ras_n && rf_kind == 2'd2) |-> cas_n);

  // R3
  ror_row_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (rf_kind == 2'd2 && $past(rf_kind) == 2'd2) |-> $stable(row_addr));

  // R5
  sr_min_hold_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sr_active) |-> (hold_cnt >= HW'(SR_MIN_CYC)));

  // R10
  start_needs_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(grant));

  // R8
  urgent_has_req_chk: assert property (@(posedge clk) disable iff (rst)
    rf_urgent |-> (rf_req || busy));
endmodule

bind rfsh_sched rfsh_sched_chk #(.ROWS(ROWS), .SR_MIN_CYC(SR_MIN_CYC)) chk_i (
  .clk(clk), .rst(rst), .grant(grant), .rf_req(rf_req), .rf_urgent(rf_urgent),
  .rf_kind(rf_kind), .row_addr(row_addr), .ras_n(ras_n), .cas_n(cas_n),
  .sr_active(sr_active), .busy(busy)
);

// File: tb/rfsh_sched_tb_top.sv
`timescale 1ns/1ps
module rfsh_sched_tb_top;
  localparam int INTERVAL = 20, ROWS = 8, T_CS = 2, T_RAS = 4, T_RP = 3;
  localparam int SR_MIN = 10, SR_RP = 5;

  logic clk = 1'b0, rst = 1'b1, row_mode = 1'b0, sr_req = 1'b0, grant = 1'b0;
  logic rf_req, rf_urgent, ras_n, cas_n, we_n, sr_active, busy;
  logic [1:0] rf_kind;
  logic [2:0] row_addr;

  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  rfsh_sched #(
    .INTERVAL(INTERVAL), .ROWS(ROWS), .OWE_MAX(15), .URGENT_TH(8),
    .T_CS(T_CS), .T_RAS(T_RAS), .T_RP(T_RP), .SR_MIN_CYC(SR_MIN), .SR_RP(SR_RP)
  ) dut_i (
    .clk(clk), .rst(rst), .row_mode(row_mode), .sr_req(sr_req), .grant(grant),
    .rf_req(rf_req), .rf_urgent(rf_urgent), .rf_kind(rf_kind), .row_addr(row_addr),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .sr_active(sr_active), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor of strobe activity
  int n_cbr, n_ror, exp_row, cas_lead, low_len, high_len, sr_len, last_sr_len, post_gap;
  bit prev_ras, prev_sr, sr_in_low, post_pend;

  always @(negedge clk) begin
    if (rst) begin
      n_cbr = 0; n_ror = 0; exp_row = 0; cas_lead = 0; low_len = 0; high_len = 0;
      sr_len = 0; last_sr_len = 0; post_gap = -1; prev_ras = 1; prev_sr = 0;
      sr_in_low = 0; post_pend = 0;
    end else begin
      if (prev_ras && !ras_n) begin
        if (!cas_n) begin
          n_cbr++;
          chk(cas_lead == T_CS, "R2 CAS lead cycles", cas_lead, T_CS);
          chk(rf_kind == 2'd1, "R2 kind code", int'(rf_kind), 1);
        end else begin
          n_ror++;
          chk(int'(row_addr) == exp_row, "R4 row sequence", int'(row_addr), exp_row);
          chk(rf_kind == 2'd2, "R3 kind code", int'(rf_kind), 2);
          exp_row = (exp_row + 1) % ROWS;
        end
        if (post_pend) begin post_gap = high_len; post_pend = 0; end
        low_len = 0; sr_in_low = 0;
      end
      if (!prev_ras && ras_n) begin
        if (!sr_in_low) chk(low_len == T_RAS, "R2/R3 RAS low width", low_len, T_RAS);
        high_len = 0;
      end
      if (!ras_n) begin
        low_len++;
        if (sr_active) sr_in_low = 1;
        if (rf_kind == 2'd2) chk(cas_n == 1'b1, "R3 CAS high in RAS-only", int'(cas_n), 1);
        chk(we_n == 1'b1, "R2 WE high", int'(we_n), 1);
      end else begin
        high_len++;
        cas_lead = cas_n ? 0 : cas_lead + 1;
      end
      if (sr_active) sr_len++;
      else if (prev_sr) begin last_sr_len = sr_len; sr_len = 0; post_pend = 1; end
      prev_ras = ras_n; prev_sr = sr_active;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk); #1;
  endtask

  task automatic do_reset();
    rst = 1; grant = 0; sr_req = 0;
    tick(3);
    rst = 0;
  endtask

  task automatic wait_idle(input string tag);
    int k;
    for (k = 0; k < 3000 && (busy || rf_req); k++) tick(1);
    chk(k < 3000, tag, k, 3000);
  endtask

  task automatic wait_busy_low(input string tag);
    int k;
    for (k = 0; k < 3000 && busy; k++) tick(1);
    chk(k < 3000, tag, k, 3000);
  endtask

  task automatic wait_sr(input string tag);
    int k;
    for (k = 0; k < 3000 && !sr_active; k++) tick(1);
    chk(k < 3000, tag, k, 3000);
  endtask

  initial begin
    tick(3);
    // R9: reset state
    chk(ras_n && cas_n && we_n, "R9 strobes high", int'({ras_n, cas_n, we_n}), 7);
    chk(!rf_req && !rf_urgent && !busy && !sr_active, "R9 flags low",
        int'({rf_req, rf_urgent, busy, sr_active}), 0);
    chk(rf_kind == 2'd0, "R9 kind none", int'(rf_kind), 0);
    rst = 0;

    // R1 first owed refresh; R10 nothing starts without grant
    tick(INTERVAL - 1);
    chk(rf_req == 1'b0, "R1 no request before interval", int'(rf_req), 0);
    tick(1);
    chk(rf_req == 1'b1, "R1 request at interval", int'(rf_req), 1);
    chk(busy == 1'b0, "R10 idle without grant", int'(busy), 0);
    // R8 urgent exactly when eight are owed
    tick(7 * INTERVAL - 1);
    chk(rf_urgent == 1'b0, "R8 urgent below threshold", int'(rf_urgent), 0);
    tick(1);
    chk(rf_urgent == 1'b1, "R8 urgent at threshold", int'(rf_urgent), 1);
    chk(n_cbr == 0, "R10 no cycles without grant", n_cbr, 0);
    grant = 1;
    wait_idle("R8 backlog drains");
    chk(rf_urgent == 1'b0, "R8 urgent clears", int'(rf_urgent), 0);
    chk(n_cbr >= 8 && n_ror == 0, "R8 backlog issued as CBR", n_cbr, 8);

    // R1 rate with grant held
    do_reset();
    grant = 1;
    tick(10 * INTERVAL + 5);
    chk(n_cbr == 10, "R1 one refresh per interval", n_cbr, 10);

    // R3/R4 RAS-only sweep across wraps
    do_reset();
    row_mode = 1; grant = 1;
    tick(20 * INTERVAL + 5);
    chk(n_ror == 20, "R4 RAS-only count", n_ror, 20);
    chk(n_cbr == 0, "R3 no CBR in row mode", n_cbr, 0);

    // R5/R6 self refresh, CBR style, early release
    do_reset();
    row_mode = 0; sr_req = 1;
    tick(3);
    chk(rf_req == 1'b1 && busy == 1'b0, "R10 sr request waits for grant",
        int'({rf_req, busy}), 2);
    grant = 1;
    wait_sr("R5 entry");
    grant = 0;
    chk(n_cbr == 1, "R5 one entry CBR", n_cbr, 1);
    tick(2);
    sr_req = 0;
    wait_busy_low("R6 exit completes");
    chk(last_sr_len == SR_MIN, "R5 minimum hold", last_sr_len, SR_MIN);
    chk(post_gap == SR_RP + T_CS, "R6 exit precharge", post_gap, SR_RP + T_CS);
    chk(n_cbr == 2, "R6 exactly one CBR after exit", n_cbr, 2);
    chk(rf_req == 1'b0, "R6 nothing owed after exit", int'(rf_req), 0);
    // R5 extended hold
    sr_req = 1; grant = 1;
    wait_sr("R5 second entry");
    grant = 0;
    tick(24);
    sr_req = 0;
    wait_busy_low("R5 second exit");
    chk(last_sr_len == 25, "R5 hold follows request", last_sr_len, 25);

    // R7 self refresh, RAS-only style
    do_reset();
    row_mode = 1; sr_req = 1; grant = 1;
    wait_sr("R7 entry");
    grant = 0;
    chk(n_ror == ROWS, "R7 sweep before entry", n_ror, ROWS);
    chk(n_cbr == 1, "R7 entry CBR", n_cbr, 1);
    sr_req = 0;
    wait_busy_low("R7 exit");
    chk(n_ror == 2 * ROWS, "R7 sweep after exit", n_ror, 2 * ROWS);
    chk(n_cbr == 1, "R7 no CBR after exit", n_cbr, 1);
    chk(post_gap == SR_RP, "R6 exit precharge row mode", post_gap, SR_RP);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule